// File: doc/BRIEF.md
# Buffered 8-bit PWM Channel

This block produces one pulse-width-modulated output level from an 8-bit counter. The counter steps once for each pulse on a `tick` clock-enable input, which comes from a prescaler outside the block. The block has two counting modes. In edge mode the counter counts up and wraps. In center mode it counts up to the period value and then back down to zero. The output is in its active phase while the counter is below the duty value. The polarity input decides whether the active phase is driven high or low.

Software writes the period, the duty and a counter clear through a small write port. While the channel runs, period and duty writes go into shadow registers. A shadow register is copied to the live compare register only at one of three moments: the end of a period, a counter clear, or the moment the channel stops. While the channel is stopped, writes reach the live registers at once.

A three-state gate controls when the channel runs:
- `GATE_OFF`: the channel is idle.
- `GATE_ARM`: the channel is enabled and waits for a tick.
- `GATE_RUN`: the channel counts.

The gate has four named transitions:
- REQUEST: OFF to ARM when `en` is high.
- ABORT: ARM to OFF when `en` drops.
- OPEN: ARM to RUN on a tick.
- CLOSE: RUN to OFF on a tick with `en` low.

Because the gate opens and closes only on ticks, it never cuts a counter step in half.

Top module: `pwm8_channel`

## Requirements
- R1: While `rst_n` is low, the gate is OFF, the counter and all period and duty registers are 0, and `pwm_out` equals the inverse of `pol`.
- R2: After `en` rises, the gate passes through ARM and enters RUN only on a clock edge where `tick` is high. That tick does not advance the counter, so the first output sample in RUN shows count 0 (or the held count).
- R3: The counter changes only on an edge where the gate is in RUN, `en` is high and `tick` is high, or on a counter clear. In every other case it holds its value, including while the gate is ARM or OFF.
- R4: In edge mode the counter runs 0, 1, ..., P-1 and then returns to 0, where P is the live period. A wrap to 0 is a period end.
- R5: In center mode the counter runs 0, 1, ..., P, P-1, ..., 1, 0, which is 2P ticks per period. Each return to 0 is a period end.
- R6: In RUN, the channel is active when duty D is nonzero and either D >= P or count < D. An active channel drives `pwm_out` = `pol`; an inactive one drives the inverse of `pol`. D = 0 therefore gives a constant inactive level, and D >= P a constant active level.
- R7: Whenever the gate is not in RUN, `pwm_out` equals the inverse of `pol`.
- R8: A period write (address 0) or duty write (address 1) made while the gate is ARM or RUN changes no output until a live-register load. A period end causes such a load.
- R9: A write to address 2 clears the counter to 0, whatever the data. It also sets the count direction to up and loads both shadows into the live registers. Address 3 has no effect.
- R10: The CLOSE transition loads both shadows into the live registers. While the gate is OFF, period and duty writes go straight to the live registers.
- R11: The `center` input is sampled only on edges where the gate is OFF. A change made while the gate is ARM or RUN is ignored until the gate is next OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled clock enable: one counter step per high cycle |
| en | input | 1 | Channel enable request |
| pol | input | 1 | Output level during the active phase |
| center | input | 1 | 1 selects up/down counting, 0 selects up-only counting |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 period, 1 duty, 2 counter clear, 3 unused |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output level |

## Verification
A gate state that is wrong shows on the output at once: an ARM or OFF state where RUN is due gives a flat inactive level instead of the first active sample. A wrong count or direction appears within one tick, as an active or inactive sample at a count where the duty comparison predicts the opposite. The checks use duty values of 1 or small values so that a single step is visible. A shadow that loads too early or too late is caught at the first sample after the write or after the expected load point. At those samples the old duty and the new duty give opposite levels.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    typedef enum logic [1:0] {
        GATE_OFF = 2'd0,
        GATE_ARM = 2'd1,
        GATE_RUN = 2'd2
    } gate_t;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DUTY = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;
endpackage

// File: rtl/pwm8_gate.sv
module pwm8_gate
    import pwm8_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  tick,
    output gate_t state_o,
    output logic  advance,
    output logic  close_evt
);
    gate_t state_q, state_d;

    // Next-state logic: the gate changes only on named transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: if (en) state_d = GATE_ARM;            // REQUEST
            GATE_ARM: begin
                if (!en)       state_d = GATE_OFF;           // ABORT
                else if (tick) state_d = GATE_RUN;           // OPEN
            end
            GATE_RUN: if (!en && tick) state_d = GATE_OFF;   // CLOSE
            default:  state_d = GATE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o   = state_q;
        advance   = (state_q == GATE_RUN) && en && tick;
        close_evt = (state_q == GATE_RUN) && !en && tick;
    end

    AST_OPEN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != GATE_RUN) |=> (state_q != GATE_RUN) || $past(tick)); // R2
endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          clr,
    input  logic          cen_mode,
    input  logic [CW-1:0] per,
    output logic [CW-1:0] cnt,
    output logic          period_end
);
    localparam int XW = CW + 1;
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d;
    logic          down_q, down_d;
    logic [XW-1:0] cnt_inc;

    assign cnt_inc = {1'b0, cnt} + XW'(1);

    always_comb begin
        cnt_d      = cnt;
        down_d     = down_q;
        period_end = 1'b0;
        if (clr) begin
            cnt_d  = '0;
            down_d = 1'b0;
        end else if (advance) begin
            if (!cen_mode) begin
                if (cnt_inc >= {1'b0, per}) begin
                    cnt_d      = '0;
                    period_end = 1'b1;
                end else begin
                    cnt_d = cnt_inc[CW-1:0];
                end
            end else if (!down_q && cnt < per) begin
                cnt_d = cnt_inc[CW-1:0];
            end else if (cnt <= ONE) begin
                cnt_d      = '0;
                down_d     = 1'b0;
                period_end = 1'b1;
            end else begin
                cnt_d  = cnt - ONE;
                down_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            down_q <= 1'b0;
        end else begin
            cnt    <= cnt_d;
            down_q <= down_d;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clr) |=> $stable(cnt)); // R3
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R9
    AST_WRAP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clr && !cen_mode && per != '0 && cnt_inc == {1'b0, per}) |=> (cnt == '0)); // R4
endmodule

// File: rtl/pwm8_bufs.sv
module pwm8_bufs #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_per,
    input  logic          wr_duty,
    input  logic [CW-1:0] wdata,
    input  logic          direct,
    input  logic          load,
    output logic [CW-1:0] per_act,
    output logic [CW-1:0] duty_act
);
    logic [CW-1:0] per_sh, duty_sh, per_nx, duty_nx;

    // A write and a load in the same cycle take the newly written value.
    assign per_nx  = wr_per  ? wdata : per_sh;
    assign duty_nx = wr_duty ? wdata : duty_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_sh   <= '0;
            duty_sh  <= '0;
            per_act  <= '0;
            duty_act <= '0;
        end else begin
            per_sh  <= per_nx;
            duty_sh <= duty_nx;
            if (direct || load) begin
                per_act  <= per_nx;
                duty_act <= duty_nx;
            end
        end
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct && !load) |=> ($stable(per_act) && $stable(duty_act))); // R8
endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
    import pwm8_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              pol,
    input  logic              center,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic              pwm_out
);
    gate_t         gate_state;
    logic          advance, close_evt, period_end;
    logic          cnt_clr, wr_per, wr_duty, buf_load, direct;
    logic          cen_q, active;
    logic [CW-1:0] cnt, per_act, duty_act;

    assign cnt_clr  = wr_en && (wr_addr == ADDR_CNT);
    assign wr_per   = wr_en && (wr_addr == ADDR_PER);
    assign wr_duty  = wr_en && (wr_addr == ADDR_DUTY);
    assign direct   = (gate_state == GATE_OFF);
    assign buf_load = period_end || cnt_clr || close_evt;

    pwm8_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .state_o   (gate_state),
        .advance   (advance),
        .close_evt (close_evt)
    );

    pwm8_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .clr        (cnt_clr),
        .cen_mode   (cen_q),
        .per        (per_act),
        .cnt        (cnt),
        .period_end (period_end)
    );

    pwm8_bufs #(.CW(CW)) u_bufs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_per   (wr_per),
        .wr_duty  (wr_duty),
        .wdata    (wr_data),
        .direct   (direct),
        .load     (buf_load),
        .per_act  (per_act),
        .duty_act (duty_act)
    );

    // The mode select is sampled only while the gate is closed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cen_q <= 1'b0;
        else if (gate_state == GATE_OFF)  cen_q <= center;
    end

    always_comb begin
        active  = (duty_act != '0) && ((duty_act >= per_act) || (cnt < duty_act));
        pwm_out = (gate_state == GATE_RUN && active) ? pol : ~pol;
    end

    AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state != GATE_RUN) |-> (pwm_out == ~pol)); // R7
    AST_CEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state != GATE_OFF) |=> $stable(cen_q)); // R11
endmodule

// File: tb/pwm8_channel_test.sv
`timescale 1ns/1ps
module pwm8_channel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, en = 1'b0, pol = 1'b1, center = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    pwm8_channel uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .pol(pol),
        .center(center), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    // period, duty, pol, center, expected high samples over one period
    localparam int NV = 9;
    localparam int VEC[NV][5] = '{
        '{10, 3, 1, 0, 3},
        '{10, 3, 0, 0, 7},
        '{ 8, 0, 1, 0, 0},
        '{ 8, 8, 1, 0, 8},
        '{ 8,12, 0, 0, 0},
        '{ 6, 2, 1, 1, 3},
        '{ 6, 6, 1, 1,12},
        '{ 5, 0, 0, 1,10},
        '{ 4, 3, 0, 1, 3}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        #1;
        chk("R1 pol=1", pwm_out, 0);
        pol = 1'b0; #1;
        chk("R1 pol=0", pwm_out, 1);
        pol = 1'b1;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1 after release", pwm_out, 0);

        // Vector table: R4 and R5 counting, R6 output level
        for (int v = 0; v < NV; v++) begin
            int highs;
            int ns;
            en = 1'b0; tick = 1'b0;
            pol = VEC[v][2][0]; center = VEC[v][3][0];
            wr(2'd0, 8'(VEC[v][0]));
            wr(2'd1, 8'(VEC[v][1]));
            wr(2'd2, 8'hA5);
            tick = 1'b1; en = 1'b1;
            step();              // REQUEST
            step();              // OPEN, count 0
            ns = (VEC[v][3] != 0) ? 2 * VEC[v][0] : VEC[v][0];
            highs = 0;
            for (int i = 0; i < ns; i++) begin
                if (pwm_out) highs++;
                step();
            end
            chk((VEC[v][3] != 0) ? "R5/R6 vector" : "R4/R6 vector", highs, VEC[v][4]);
            chk("R4/R5 back at count 0", pwm_out, (VEC[v][1] != 0) ? VEC[v][2] : 1 - VEC[v][2]);
            en = 1'b0;
            step();              // CLOSE
            chk("R7 disabled level", pwm_out, 1 - VEC[v][2]);
            tick = 1'b0;
        end

        // R2/R3 enable alignment to tick
        pol = 1'b1; center = 1'b0;
        wr(2'd0, 8'd10); wr(2'd1, 8'd1); wr(2'd2, 8'd0);
        en = 1'b1;
        for (int i = 0; i < 4; i++) step();
        chk("R2 armed waits for tick", pwm_out, 0);
        tick = 1'b1; step();
        chk("R2 opens at tick, count 0", pwm_out, 1);
        tick = 1'b0;
        for (int i = 0; i < 3; i++) step();
        chk("R3 holds without tick", pwm_out, 1);
        tick = 1'b1; step(); tick = 1'b0;
        chk("R3 steps on tick", pwm_out, 0);

        // R8 buffered duty loads at period end (count now 1)
        wr(2'd1, 8'd8);
        chk("R8 write buffered", pwm_out, 0);
        tick = 1'b1;
        for (int i = 0; i < 8; i++) step();
        chk("R8 count 9 old duty", pwm_out, 0);
        step();
        chk("R8 wrap to 0", pwm_out, 1);
        step();
        tick = 1'b0;
        chk("R8 new duty after period end", pwm_out, 1);

        // R9 counter clear loads shadows (count 1, duty 8)
        wr(2'd1, 8'd1);
        chk("R9 duty still buffered", pwm_out, 1);
        wr(2'd3, 8'd0);
        chk("R9 address 3 no effect", pwm_out, 1);
        wr(2'd2, 8'hFF);
        chk("R9 cleared to 0", pwm_out, 1);
        tick = 1'b1; step(); tick = 1'b0;
        chk("R9 loaded duty 1", pwm_out, 0);

        // R10 CLOSE loads shadows (count 1, duty 1)
        wr(2'd1, 8'd5);
        chk("R10 buffered before close", pwm_out, 0);
        en = 1'b0; tick = 1'b1; step(); tick = 1'b0;
        chk("R7 off after close", pwm_out, 0);
        en = 1'b1; step();
        tick = 1'b1; step(); tick = 1'b0;
        chk("R10 close loaded duty 5", pwm_out, 1);

        // R11 center change ignored while running
        center = 1'b1;
        wr(2'd0, 8'd4); wr(2'd1, 8'd1); wr(2'd2, 8'd0);
        tick = 1'b1;
        for (int i = 0; i < 4; i++) step();
        chk("R11 still edge mode, wrapped", pwm_out, 1);
        en = 1'b0; step();
        tick = 1'b0; step();
        wr(2'd1, 8'd3);
        en = 1'b1; tick = 1'b1;
        step(); step();
        for (int i = 0; i < 4; i++) step();
        chk("R11/R5 center mode reaches count 4", pwm_out, 0);
        step(); step();
        chk("R10 direct write duty 3 at count 2", pwm_out, 1);
        tick = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule